// File: doc/BRIEF.md
# Bit-Sliced Two-Bank Synchronous Memory

This block is a synchronous word memory assembled from identical one-bit storage slices. Each slice keeps a single bit position for every location it covers. The slices sit side by side on a shared address, so together they make up the full data word. With this arrangement, a wider word only needs more slices and leaves the address range unchanged.

The slices form two equal banks. The most significant address bit enables one bank directly and enables the other through its inverse. Adding this one address line therefore doubles the capacity without changing the data width.

A requester drives active-low chip-select, write-enable and output-enable controls:

- A selected write stores the data word in the addressed location.
- A selected read with output enable returns the word on the next clock, with a valid flag asserted alongside it.
- When no read data is being returned, the data output is held at zero and the valid flag is low. This models a released bus.

Top module: `bitslice_mem`

## Requirements
- R1: Every data bit is stored in its own one-bit slice. All slices share the address, so a word written to a location reads back with every bit intact.
- R2: Locations are addressed linearly from 0 to DEPTH-1, and every address holds its own word, including 0 and DEPTH-1.
- R3: The top address bit picks the bank (0 picks the lower bank, 1 the upper). Exactly one bank is enabled per selected access, so two addresses differing only in that bit hold independent words.
- R4: While csN is high, all other inputs are ignored. A write leaves memory unchanged, and a read produces rdValid=0 and rdData=0 on the next cycle.
- R5: A selected cycle with weN high and oeN high gives rdValid=0 and rdData=0 on the next cycle.
- R6: A read is a cycle with csN=0, weN=1 and oeN=0. Its word appears on rdData one clock later, with rdValid=1 in that same cycle, and back-to-back reads return one word per cycle.
- R7: A cycle with csN=0, weN=0 and oeN=0 performs the write, and the next cycle shows rdValid=0 and rdData=0.
- R8: After reset, rdValid is 0 and rdData is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address; top bit selects the bank |
| wrData | input | WORD_W | Word to write |
| csN | input | 1 | Active-low chip select |
| weN | input | 1 | Active-low write enable |
| oeN | input | 1 | Active-low output enable |
| rdData | output | WORD_W | Read word, zero when not valid |
| rdValid | output | 1 | High in the cycle read data is presented |

## Verification
The bench targets addresses that differ only in the bank bit. A bank decode that enabled both banks, or neither, would overwrite the partner word or return a stale one. Deselected writes are issued and then read back: a design that honoured weN while unselected would corrupt the stored word. The cycle with write and output enable both active is checked for an empty output followed by correct stored data. Back-to-back reads and a full address sweep expose an off-by-one in latency or a slice wired to the wrong bit.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  localparam int NUM_BANKS = 2;

  typedef struct packed {
    logic                 wrEn;
    logic                 rdEn;
    logic [NUM_BANKS-1:0] bankEn;
  } bsm_strobe_t;
endpackage

// File: rtl/bsm_slice.sv
module bsm_slice #(
  parameter int SLICE_DEPTH = 32,
  localparam int AW = $clog2(SLICE_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic          d,
  output logic          q
);
  logic [SLICE_DEPTH-1:0] bits;

  always_ff @(posedge clk) begin
    if (we) bits[addr] <= d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (re) q <= bits[addr];
  end
endmodule

// File: rtl/bsm_ctrl.sv
module bsm_ctrl
  import bsm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csN,
  input  logic        weN,
  input  logic        oeN,
  input  logic        bankBit,
  output bsm_strobe_t strobes,
  output logic        rdValid
);
  logic selected;

  assign selected        = ~csN;
  assign strobes.wrEn    = selected & ~weN;
  assign strobes.rdEn    = selected & weN & ~oeN;
  assign strobes.bankEn  = selected ? {bankBit, ~bankBit} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdValid <= 1'b0;
    else        rdValid <= strobes.rdEn;
  end

  p_one_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !csN |-> $countones(strobes.bankEn) == 1);

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!csN && weN && !oeN) |=> rdValid);

  p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!csN && !weN) |=> !rdValid);

  p_deselect_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    csN |=> !rdValid);

  p_no_oe_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!csN && weN && oeN) |=> !rdValid);
endmodule

// File: rtl/bsm_datapath.sv
module bsm_datapath
  import bsm_pkg::*;
#(
  parameter int WORD_W     = 8,
  parameter int BANK_DEPTH = 32,
  localparam int LOW_W = $clog2(BANK_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bsm_strobe_t       strobes,
  input  logic [LOW_W-1:0]  lowAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdValid,
  output logic [WORD_W-1:0] rdData
);
  logic [WORD_W-1:0] bankQ [NUM_BANKS];
  logic              selQ;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bankWe;
    logic bankRe;
    assign bankWe = strobes.wrEn & strobes.bankEn[b];
    assign bankRe = strobes.rdEn & strobes.bankEn[b];
    for (genvar s = 0; s < WORD_W; s++) begin : g_slice
      bsm_slice #(.SLICE_DEPTH(BANK_DEPTH)) u_slice (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (bankWe),
        .re   (bankRe),
        .addr (lowAddr),
        .d    (wrData[s]),
        .q    (bankQ[b][s])
      );
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               selQ <= 1'b0;
    else if (strobes.rdEn)    selQ <= strobes.bankEn[1];
  end

  assign rdData = rdValid ? bankQ[selQ] : '0;

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.wrEn && strobes.rdEn));

  p_released_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rdValid |-> rdData == '0);
endmodule

// File: rtl/bitslice_mem.sv
module bitslice_mem
  import bsm_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DEPTH  = 64,
  localparam int ADDR_W     = $clog2(DEPTH),
  localparam int BANK_DEPTH = DEPTH / NUM_BANKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              csN,
  input  logic              weN,
  input  logic              oeN,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid
);
  bsm_strobe_t strobes;

  bsm_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .csN    (csN),
    .weN    (weN),
    .oeN    (oeN),
    .bankBit(addr[ADDR_W-1]),
    .strobes(strobes),
    .rdValid(rdValid)
  );

  bsm_datapath #(.WORD_W(WORD_W), .BANK_DEPTH(BANK_DEPTH)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobes(strobes),
    .lowAddr(addr[ADDR_W-2:0]),
    .wrData (wrData),
    .rdValid(rdValid),
    .rdData (rdData)
  );
endmodule

// File: tb/bitslice_mem_bench.sv
module bitslice_mem_bench;
  localparam int WORD_W = 8;
  localparam int DEPTH  = 64;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int HALF   = DEPTH / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [WORD_W-1:0] wrData = '0;
  logic csN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [WORD_W-1:0] rdData;
  logic rdValid;

  int total = 0, failed = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bitslice_mem #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_bitslice_mem (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wrData(wrData),
    .csN(csN), .weN(weN), .oeN(oeN), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive one cycle at a negedge, return at the next negedge (outputs updated)
  task automatic drive(logic [ADDR_W-1:0] a, logic [WORD_W-1:0] d,
                       logic cs, logic we, logic oe);
    @(negedge clk);
    addr = a; wrData = d; csN = cs; weN = we; oeN = oe;
    @(negedge clk);
    csN = 1'b1; weN = 1'b1; oeN = 1'b1;
  endtask

  task automatic writeWord(int a, int d);
    drive(a[ADDR_W-1:0], d[WORD_W-1:0], 1'b0, 1'b0, 1'b1);
  endtask

  task automatic readWord(string tag, int a, int exp);
    drive(a[ADDR_W-1:0], '0, 1'b0, 1'b1, 1'b0);
    chk({tag, " valid"}, rdValid, 1);
    chk({tag, " data"}, rdData, exp);
  endtask

  task automatic testReset();
    chk("R8 reset valid", rdValid, 0);
    chk("R8 reset data", rdData, 0);
  endtask

  task automatic testPatterns();
    writeWord(0, 8'hA5); writeWord(1, 8'h5A); writeWord(DEPTH-1, 8'hFF);
    writeWord(HALF-1, 8'h00); writeWord(HALF, 8'h3C);
    readWord("R1 pattern a5", 0, 8'hA5);
    readWord("R1 pattern 5a", 1, 8'h5A);
    readWord("R2 top addr", DEPTH-1, 8'hFF);
    readWord("R2 bank edge low", HALF-1, 8'h00);
    readWord("R2 bank edge high", HALF, 8'h3C);
  endtask

  task automatic testBanks();
    writeWord(5, 8'h11);
    writeWord(5 + HALF, 8'hEE);
    readWord("R3 lower bank", 5, 8'h11);
    readWord("R3 upper bank", 5 + HALF, 8'hEE);
  endtask

  task automatic testDeselect();
    drive(5, 8'h77, 1'b1, 1'b0, 1'b1);
    drive(5 + HALF, 8'h77, 1'b1, 1'b0, 1'b0);
    drive(5, 8'h00, 1'b1, 1'b1, 1'b0);
    chk("R4 deselect valid", rdValid, 0);
    chk("R4 deselect data", rdData, 0);
    readWord("R4 lower unchanged", 5, 8'h11);
    readWord("R4 upper unchanged", 5 + HALF, 8'hEE);
  endtask

  task automatic testNoOe();
    drive(5, 8'h00, 1'b0, 1'b1, 1'b1);
    chk("R5 no oe valid", rdValid, 0);
    chk("R5 no oe data", rdData, 0);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    addr = 0; csN = 0; weN = 1; oeN = 0;
    @(negedge clk);
    chk("R6 b2b first valid", rdValid, 1);
    chk("R6 b2b first data", rdData, 8'hA5);
    addr = 5 + HALF;
    @(negedge clk);
    chk("R6 b2b second valid", rdValid, 1);
    chk("R6 b2b second data", rdData, 8'hEE);
    csN = 1; weN = 1; oeN = 1;
    @(negedge clk);
    chk("R6 valid drops", rdValid, 0);
  endtask

  task automatic testWriteWins();
    drive(9, 8'h42, 1'b0, 1'b0, 1'b0);
    chk("R7 no read valid", rdValid, 0);
    chk("R7 no read data", rdData, 0);
    readWord("R7 write done", 9, 8'h42);
  endtask

  task automatic testSweep();
    for (int a = 0; a < DEPTH; a++) writeWord(a, (a * 37 + 3) & 8'hFF);
    for (int a = 0; a < DEPTH; a++) readWord("R2 sweep", a, (a * 37 + 3) & 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    testPatterns();
    testBanks();
    testDeselect();
    testNoOe();
    testBackToBack();
    testWriteWins();
    testSweep();
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule